// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Scan-Line Buffer

This block holds pixel data for a bitmap display, one scan line at a time. A fetch engine in the system-clock domain delivers 32-bit words in bursts. Each accepted word goes into the buffer at a running fill column, and that column steps forward by one word after each write. On the video clock the scan side presents a pixel column and receives one 8-bit pixel.

The storage has two halves of 512 words each. The parity of the current pixel row selects the half. The scan side reads the half equal to the parity, and the fill side writes the opposite half, so the next line is loaded while the current one is shown. Inside each stored word the pixels are big-endian: the lowest column of the group of four comes from the most significant byte.

Top module: `scanline_pingpong_buf`

## Requirements
- R1: A word is stored, and the fill column moves, only on a system-clock edge where `fill_en` and `fill_ack` are both high. With either one low, no stored data changes.
- R2: A write goes to the half selected by the inverse of `fill_row_par`. The scan side reads the half selected by `scan_row_par` itself. Data written while `fill_row_par` is 1 is read back with `scan_row_par` at 0, and the other half is left untouched.
- R3: A system-clock edge with `fill_col_load` high sets the fill column to `fill_col_start`. Each write adds 4 to the fill column. The word index of a write is fill column bits [10:2].
- R4: Scan columns 4k, 4k+1, 4k+2 and 4k+3 return bits [31:24], [23:16], [15:8] and [7:0] of stored word k.
- R5: `pix_out` shows the pixel for the `scan_col`/`scan_row_par` sampled at one video-clock edge after the following video-clock edge, which is two edges of latency. After only the first of those edges it still shows the previous pixel.
- R6: While either reset is asserted (active low, asynchronous), `pix_out` is 0 and the fill column is 0.
- R7: Column bit 11 plays no part in addressing. A fill column that counts past 2047 wraps to word 0, and scan column 2048+c reads the same pixel as column c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fill-side clock |
| sys_rst_n | input | 1 | Fill-side reset, active low |
| fill_en | input | 1 | Fill port enable (a bus cycle is active) |
| fill_ack | input | 1 | Write strobe (memory acknowledge for this word) |
| fill_row_par | input | 1 | Row parity seen by the fill side |
| fill_col_load | input | 1 | Load the fill column from `fill_col_start` |
| fill_col_start | input | 12 | Byte column at which a burst begins |
| fill_data | input | 32 | Word to store |
| vid_clk | input | 1 | Scan-side clock |
| vid_rst_n | input | 1 | Scan-side reset, active low |
| scan_row_par | input | 1 | Row parity seen by the scan side |
| scan_col | input | 12 | Pixel column to read |
| pix_out | output | 8 | Registered pixel |

## Verification
Two situations are hard to reach from the ports. The first is a fill column that crosses word 511 and wraps into word 0 of the same half. The bench loads a start column of 2044 and writes two words, then reads back both the last group of pixels and the first group. The second is proof that a stalled strobe, or an acknowledge with no enable, neither stores data nor skips a word. The bench places such cycles, each carrying a distinct poison word, in the middle of a burst. It then checks that the columns on both sides of each stall are contiguous and hold no poison byte.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int LB_PIX_W      = 8;
  localparam int LB_LANES      = 4;
  localparam int LB_HALF_WORDS = 512;

  // Byte lane inside a word for a given column (column 0 maps to the top lane).
  function automatic int unsigned lane_for_col(input int unsigned col, input int unsigned lanes);
    return (lanes - 1) - (col % lanes);
  endfunction
endpackage

// File: rtl/lb_rst_sync.sv
module lb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/lb_fill_addr.sv
module lb_fill_addr #(
  parameter int COL_W   = 12,
  parameter int LANE_W  = 2,
  parameter int WIDX_W  = 9,
  localparam int WADDR_W = WIDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ack,
  input  logic               row_par,
  input  logic               col_load,
  input  logic [COL_W-1:0]   col_start,
  output logic [COL_W-1:0]   col,
  output logic               we,
  output logic [WADDR_W-1:0] waddr
);
  localparam logic [COL_W-1:0] STEP = COL_W'(1 << LANE_W);

  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] col_d;
  logic             col_ce;

  assign we = en & ack;

  always_comb begin
    col_ce = col_load | we;
    col_d  = col_q;
    if (col_load) col_d = col_start;
    else if (we)  col_d = col_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (col_ce) col_q <= col_d;
  end

  assign col   = col_q;
  assign waddr = {~row_par, col_q[LANE_W +: WIDX_W]};
endmodule

// File: rtl/lb_scan_addr.sv
module lb_scan_addr #(
  parameter int COL_W  = 12,
  parameter int LANE_W = 2,
  parameter int WIDX_W = 9,
  localparam int RADDR_W = 1 + WIDX_W + LANE_W
) (
  input  logic               row_par,
  input  logic [COL_W-1:0]   col,
  output logic [RADDR_W-1:0] raddr
);
  assign raddr = {row_par, col[LANE_W +: WIDX_W], ~col[LANE_W-1:0]};
endmodule

// File: rtl/lb_dual_ram.sv
module lb_dual_ram #(
  parameter int PIX_W   = 8,
  parameter int LANES   = 4,
  parameter int WADDR_W = 10,
  localparam int WORD_W  = PIX_W * LANES,
  localparam int LANE_W  = $clog2(LANES),
  localparam int DEPTH   = 1 << WADDR_W,
  localparam int RADDR_W = WADDR_W + LANE_W
) (
  input  logic               wclk,
  input  logic               we,
  input  logic [WADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               rclk,
  input  logic               rst_n,
  input  logic [RADDR_W-1:0] raddr,
  output logic [PIX_W-1:0]   rdata
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] lane_q;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    word_q <= mem[raddr[RADDR_W-1:LANE_W]];
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= raddr[LANE_W-1:0];
  end

  always_comb begin
    rdata = word_q[lane_q*PIX_W +: PIX_W];
  end
endmodule

// File: rtl/scanline_pingpong_buf.sv
module scanline_pingpong_buf
  import lb_pkg::*;
#(
  parameter int PIX_W      = LB_PIX_W,
  parameter int LANES      = LB_LANES,
  parameter int HALF_WORDS = LB_HALF_WORDS,
  localparam int WORD_W  = PIX_W * LANES,
  localparam int LANE_W  = $clog2(LANES),
  localparam int WIDX_W  = $clog2(HALF_WORDS),
  localparam int WADDR_W = WIDX_W + 1,
  localparam int RADDR_W = WADDR_W + LANE_W,
  localparam int COL_W   = WIDX_W + LANE_W + 1
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              fill_en,
  input  logic              fill_ack,
  input  logic              fill_row_par,
  input  logic              fill_col_load,
  input  logic [COL_W-1:0]  fill_col_start,
  input  logic [WORD_W-1:0] fill_data,
  input  logic              vid_clk,
  input  logic              vid_rst_n,
  input  logic              scan_row_par,
  input  logic [COL_W-1:0]  scan_col,
  output logic [PIX_W-1:0]  pix_out
);
  logic               sys_rst_s;
  logic               vid_rst_s;
  logic [COL_W-1:0]   fill_col;
  logic               wr_we;
  logic [WADDR_W-1:0] wr_addr;
  logic [RADDR_W-1:0] rd_addr;
  logic [PIX_W-1:0]   ram_pix;
  logic [PIX_W-1:0]   pix_q;

  lb_rst_sync #(.STAGES(2)) u_sys_rst (
    .clk(sys_clk), .rst_n_in(sys_rst_n), .rst_n_out(sys_rst_s));

  lb_rst_sync #(.STAGES(2)) u_vid_rst (
    .clk(vid_clk), .rst_n_in(vid_rst_n), .rst_n_out(vid_rst_s));

  lb_fill_addr #(.COL_W(COL_W), .LANE_W(LANE_W), .WIDX_W(WIDX_W)) u_fill (
    .clk(sys_clk), .rst_n(sys_rst_s), .en(fill_en), .ack(fill_ack),
    .row_par(fill_row_par), .col_load(fill_col_load), .col_start(fill_col_start),
    .col(fill_col), .we(wr_we), .waddr(wr_addr));

  lb_scan_addr #(.COL_W(COL_W), .LANE_W(LANE_W), .WIDX_W(WIDX_W)) u_scan (
    .row_par(scan_row_par), .col(scan_col), .raddr(rd_addr));

  lb_dual_ram #(.PIX_W(PIX_W), .LANES(LANES), .WADDR_W(WADDR_W)) u_ram (
    .wclk(sys_clk), .we(wr_we), .waddr(wr_addr), .wdata(fill_data),
    .rclk(vid_clk), .rst_n(vid_rst_s), .raddr(rd_addr), .rdata(ram_pix));

  always_ff @(posedge vid_clk or negedge vid_rst_s) begin
    if (!vid_rst_s) pix_q <= '0;
    else            pix_q <= ram_pix;
  end

  assign pix_out = pix_q;
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
  parameter int COL_W   = 12,
  parameter int PIX_W   = 8,
  parameter int WADDR_W = 10,
  parameter int LANE_W  = 2
) (
  input logic               sys_clk,
  input logic               sys_rst_s,
  input logic               fill_en,
  input logic               fill_ack,
  input logic               fill_row_par,
  input logic               fill_col_load,
  input logic [COL_W-1:0]   fill_col_start,
  input logic [COL_W-1:0]   fill_col,
  input logic               wr_we,
  input logic [WADDR_W-1:0] wr_addr,
  input logic               vid_clk,
  input logic               vid_rst_s,
  input logic [PIX_W-1:0]   pix_out
);
  assert_hold_when_idle_R1: assert property (@(posedge sys_clk) disable iff (!sys_rst_s)
    (!(fill_en && fill_ack) && !fill_col_load) |=> $stable(fill_col));

  assert_no_write_when_idle_R1: assert property (@(posedge sys_clk) disable iff (!sys_rst_s)
    !(fill_en && fill_ack) |-> !wr_we);

  assert_step_per_write_R3: assert property (@(posedge sys_clk) disable iff (!sys_rst_s)
    (fill_en && fill_ack && !fill_col_load) |=> fill_col == $past(fill_col) + COL_W'(1 << LANE_W));

  assert_load_start_R3: assert property (@(posedge sys_clk) disable iff (!sys_rst_s)
    fill_col_load |=> fill_col == $past(fill_col_start));

  assert_opposite_half_R2: assert property (@(posedge sys_clk) disable iff (!sys_rst_s)
    wr_we |-> wr_addr[WADDR_W-1] != fill_row_par);

  always @(posedge vid_clk) begin
    if (!vid_rst_s) assert_reset_pixel_R6: assert (pix_out == '0);
  end
endmodule

bind scanline_pingpong_buf lb_checker #(
  .COL_W(COL_W), .PIX_W(PIX_W), .WADDR_W(WADDR_W), .LANE_W(LANE_W)
) u_chk (
  .sys_clk(sys_clk), .sys_rst_s(sys_rst_s), .fill_en(fill_en), .fill_ack(fill_ack),
  .fill_row_par(fill_row_par), .fill_col_load(fill_col_load),
  .fill_col_start(fill_col_start), .fill_col(fill_col), .wr_we(wr_we),
  .wr_addr(wr_addr), .vid_clk(vid_clk), .vid_rst_s(vid_rst_s), .pix_out(pix_out));

// File: tb/sim_scanline_pingpong_buf.sv
module sim_scanline_pingpong_buf;
  logic        sys_clk = 1'b0;
  logic        vid_clk = 1'b0;
  logic        sys_rst_n, vid_rst_n;
  logic        fill_en, fill_ack, fill_row_par, fill_col_load;
  logic [11:0] fill_col_start;
  logic [31:0] fill_data;
  logic        scan_row_par;
  logic [11:0] scan_col;
  logic [7:0]  pix_out;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  always #10 sys_clk = ~sys_clk;
  always #7  vid_clk = ~vid_clk;

  scanline_pingpong_buf u0 (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .fill_en(fill_en), .fill_ack(fill_ack),
    .fill_row_par(fill_row_par), .fill_col_load(fill_col_load),
    .fill_col_start(fill_col_start), .fill_data(fill_data), .vid_clk(vid_clk),
    .vid_rst_n(vid_rst_n), .scan_row_par(scan_row_par), .scan_col(scan_col),
    .pix_out(pix_out));

  function automatic logic [7:0] pat(input int half, input int col);
    logic [7:0] c8;
    c8 = 8'(col);
    return half == 0 ? ((c8 * 8'd7) ^ 8'h3C) : ((c8 * 8'd13) ^ 8'hC5);
  endfunction

  function automatic logic [31:0] word_of(input int half, input int col0);
    return {pat(half, col0), pat(half, col0 + 1), pat(half, col0 + 2), pat(half, col0 + 3)};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_col(input logic [11:0] start);
    @(negedge sys_clk);
    fill_col_load = 1'b1; fill_col_start = start;
    @(negedge sys_clk);
    fill_col_load = 1'b0;
  endtask

  task automatic put_word(input logic en, input logic ack, input logic [31:0] d);
    @(negedge sys_clk);
    fill_en = en; fill_ack = ack; fill_data = d;
    @(negedge sys_clk);
    fill_en = 1'b0; fill_ack = 1'b0;
  endtask

  task automatic read_pix(input logic par, input logic [11:0] col, output logic [7:0] v);
    @(negedge vid_clk);
    scan_row_par = par; scan_col = col;
    @(posedge vid_clk);
    @(posedge vid_clk);
    @(negedge vid_clk);
    v = pix_out;
  endtask

  task automatic t_reset();
    @(negedge vid_clk);
    check("R6 pixel during reset", pix_out, 8'h00);
  endtask

  task automatic t_fill_half0();
    logic [7:0] v;
    fill_row_par = 1'b1;
    load_col(12'd0);
    for (int w = 0; w < 8; w++) put_word(1'b1, 1'b1, word_of(0, 4 * w));
    for (int c = 0; c < 32; c++) begin
      read_pix(1'b0, 12'(c), v);
      check("R2 R3 R4 half0 byte order", v, pat(0, c));
    end
  endtask

  task automatic t_stall();
    logic [7:0] v;
    fill_row_par = 1'b1;
    load_col(12'd64);
    put_word(1'b1, 1'b1, word_of(0, 64));
    put_word(1'b1, 1'b0, 32'hDEADBEEF);
    put_word(1'b0, 1'b1, 32'hBADC0FFE);
    put_word(1'b1, 1'b1, word_of(0, 68));
    for (int c = 64; c < 72; c++) begin
      read_pix(1'b0, 12'(c), v);
      check("R1 stalled strobe stores nothing", v, pat(0, c));
    end
  endtask

  task automatic t_fill_half1();
    logic [7:0] v;
    fill_row_par = 1'b0;
    load_col(12'd0);
    for (int w = 0; w < 4; w++) put_word(1'b1, 1'b1, word_of(1, 4 * w));
    for (int c = 0; c < 16; c++) begin
      read_pix(1'b1, 12'(c), v);
      check("R2 half1 readback", v, pat(1, c));
      read_pix(1'b0, 12'(c), v);
      check("R2 half0 untouched", v, pat(0, c));
    end
  endtask

  task automatic t_latency();
    logic [7:0] v;
    read_pix(1'b0, 12'd1, v);
    @(negedge vid_clk);
    scan_row_par = 1'b0; scan_col = 12'd6;
    @(posedge vid_clk);
    @(negedge vid_clk);
    check("R5 one edge keeps old pixel", pix_out, pat(0, 1));
    @(posedge vid_clk);
    @(negedge vid_clk);
    check("R5 two edges give new pixel", pix_out, pat(0, 6));
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    fill_row_par = 1'b1;
    load_col(12'd2044);
    put_word(1'b1, 1'b1, word_of(1, 2044));
    put_word(1'b1, 1'b1, word_of(1, 2048));
    for (int c = 2044; c < 2048; c++) begin
      read_pix(1'b0, 12'(c), v);
      check("R7 last word of half", v, pat(1, c));
    end
    for (int c = 0; c < 4; c++) begin
      read_pix(1'b0, 12'(c), v);
      check("R7 wrap to word 0", v, pat(1, 2048 + c));
    end
    read_pix(1'b0, 12'(2048 + 5), v);
    check("R7 column bit 11 ignored", v, pat(0, 5));
  endtask

  initial begin
    sys_rst_n = 1'b0; vid_rst_n = 1'b0;
    fill_en = 1'b0; fill_ack = 1'b0; fill_row_par = 1'b0; fill_col_load = 1'b0;
    fill_col_start = '0; fill_data = '0; scan_row_par = 1'b0; scan_col = '0;
    repeat (3) @(posedge sys_clk);
    t_reset();
    @(negedge sys_clk); sys_rst_n = 1'b1;
    @(negedge vid_clk); vid_rst_n = 1'b1;
    repeat (4) @(posedge sys_clk);
    repeat (4) @(posedge vid_clk);
    t_fill_half0();
    t_stall();
    t_fill_half1();
    t_latency();
    t_wrap();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule